// File: doc/BRIEF.md
# Pulse-Width Tape Block Encoder

This block turns one block of bytes into a square-wave cassette signal. After a start command it sends a steady pilot tone. The pilot is followed by a short two-part sync pulse. The data part comes next: a marker byte, the payload bytes taken from a valid/ready stream, and a trailing XOR checksum byte that the block computes itself. Each bit is coded by the length of its wave. A zero bit is a short full wave and a one bit is a wave twice as long.

All timing is counted in CPU-clock ticks. Ticks are delivered through a one-cycle `tick` enable, so the block can run from a fast system clock and still reproduce the original tape timing exactly. A one-byte holding register takes the next payload byte ahead of time. If the stream cannot supply a byte by the time it is needed, the encoder pauses between half-periods and never stretches one.

Top module: `tape_encoder`

## Requirements
- R1: While reset is held and after it is released, `tape_out`, `busy`, `done` and `in_ready` are all low.
- R2: When `pilot_halves` is nonzero, the frame begins with exactly that many half-periods of HP_PILOT (2168) ticks each.
- R3: When `pilot_halves` is zero, the pilot length is PILOT_HDR (8063) half-periods if `marker` is 0x00 and PILOT_DAT (3223) half-periods for any other marker.
- R4: The pilot is followed by one half-period of HP_SYNC_A (667) ticks and then one of HP_SYNC_B (735) ticks.
- R5: Each data bit is two equal half-periods. A 0 uses HP_ZERO (855) ticks per half and a 1 uses HP_ONE (1710) ticks per half. Bits go out most significant bit first.
- R6: After the sync come the marker byte, then exactly `pay_len` payload bytes in stream order, then one checksum byte.
- R7: The checksum byte is the XOR of the marker and all payload bytes. With `pay_len` = 0 it equals the marker.
- R8: `tape_out` inverts at the end of every half-period, starting from whatever level it held before the start command.
- R9: After the last half-period, `tape_out` keeps its level, `done` is high for exactly one cycle and `busy` is low from that same cycle on.
- R10: If the next payload byte has not been received when the previous byte finishes, no half-period starts and `tape_out` holds its level until the byte arrives. The half-periods that follow keep their exact lengths.
- R11: A start command given while `busy` is high has no effect on the frame being sent.
- R12: `in_ready` is high only while busy and only while payload bytes remain to be fetched, so exactly `pay_len` bytes are accepted per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle enable, one per CPU-clock tick |
| start | input | 1 | Begin a frame; taken only when idle |
| marker | input | 8 | Marker byte for the frame |
| pilot_halves | input | PIL_W | Pilot half-period count; 0 selects the default for the marker |
| pay_len | input | LEN_W | Number of payload bytes |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Encoder accepts a byte this cycle |
| tape_out | output | 1 | Square-wave tape level |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at end of frame |

## Verification
The bench shrinks all timing constants so it can send whole frames. It sweeps pilot counts of 1 and 3 and both default pilot lengths, which separates an explicit count from the marker-selected default. Payload lengths of 0, 1, 5 and 17 are used with all-zero, all-one, alternating and counting byte patterns. These patterns separate the two bit lengths, the bit order and the checksum fold. Each pattern runs with ticks every cycle, every third cycle and in a pseudo-random pattern, to confirm that timing follows ticks rather than clocks. Two further frames show the stall behaviour and confirm that start requests arriving mid-frame are ignored.

// File: rtl/tape_enc_pkg.sv
// Shared types for the tape block encoder.
// Assumes nothing beyond IEEE 1800-2017 enums.
package tape_enc_pkg;

    // Frame phase of the sequencer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PILOT,
        PH_SYNC_A,
        PH_SYNC_B,
        PH_BYTE,
        PH_WAIT
    } phase_e;

    // Which kind of byte is being shifted out
    typedef enum logic [1:0] {
        BK_MARK,
        BK_PAY,
        BK_SUM
    } bkind_e;

endpackage

// File: rtl/tape_halfper_timer.sv
// Half-period timer: counts a loaded duration down in ticks.
// expire is high in the cycle whose tick completes the duration.
// Assumes load is only raised when the timer is idle or expiring.
module tape_halfper_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] dur,
    output logic             expire
);

    logic [CNT_W-1:0] rem;

    // Last tick of a running half-period
    assign expire = tick && (rem == CNT_W'(1));

    // Remaining ticks of the current half-period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (load) begin
            rem <= dur;
        end else if (tick && rem != '0) begin
            rem <= rem - CNT_W'(1);
        end
    end

endmodule

// File: rtl/tape_byte_feed.sv
// One-byte prefetch buffer between the payload stream and the encoder.
// Accepts at most the programmed number of bytes per frame.
// Assumes begin_i is only raised while the encoder is idle.
module tape_byte_feed #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             begin_i,
    input  logic [LEN_W-1:0] len,
    input  logic             take,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             has_byte,
    output logic [7:0]       byte_o
);

    logic [LEN_W-1:0] left;
    logic             full;
    logic [7:0]       hold;

    assign in_ready = !full && (left != '0);
    assign has_byte = full;
    assign byte_o   = hold;

    // Fill from the stream, empty on take, rearm on begin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
            full <= 1'b0;
            hold <= '0;
        end else if (begin_i) begin
            left <= len;
            full <= 1'b0;
        end else if (in_valid && in_ready) begin
            hold <= in_data;
            full <= 1'b1;
            left <= left - LEN_W'(1);
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/tape_encoder.sv
// Tape block encoder: pilot, two-part sync, marker, payload, checksum,
// each bit coded as two equal half-periods whose length marks 0 or 1.
// Assumes tick is a one-cycle enable and pilot_halves fits PIL_W.
module tape_encoder
    import tape_enc_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int LEN_W     = 16,
    parameter int PIL_W     = 14,
    parameter int HP_PILOT  = 2168,
    parameter int HP_SYNC_A = 667,
    parameter int HP_SYNC_B = 735,
    parameter int HP_ZERO   = 855,
    parameter int HP_ONE    = 1710,
    parameter int PILOT_HDR = 8063,
    parameter int PILOT_DAT = 3223
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [7:0]       marker,
    input  logic [PIL_W-1:0] pilot_halves,
    input  logic [LEN_W-1:0] pay_len,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             tape_out,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] D_PILOT  = CNT_W'(HP_PILOT);
    localparam logic [CNT_W-1:0] D_SYNC_A = CNT_W'(HP_SYNC_A);
    localparam logic [CNT_W-1:0] D_SYNC_B = CNT_W'(HP_SYNC_B);
    localparam logic [CNT_W-1:0] D_ZERO   = CNT_W'(HP_ZERO);
    localparam logic [CNT_W-1:0] D_ONE    = CNT_W'(HP_ONE);
    localparam logic [PIL_W-1:0] N_HDR    = PIL_W'(PILOT_HDR);
    localparam logic [PIL_W-1:0] N_DAT    = PIL_W'(PILOT_DAT);

    // Half-period length for one data bit
    function automatic logic [CNT_W-1:0] dur_of(input logic b);
        return b ? D_ONE : D_ZERO;
    endfunction

    phase_e           phase, nx_phase;
    bkind_e           kind, nx_kind;
    logic             level, nx_level;
    logic             busy_q, nx_busy;
    logic             done_q, nx_done;
    logic [PIL_W-1:0] pil_left, nx_pil_left;
    logic [LEN_W-1:0] pay_left, nx_pay_left;
    logic [7:0]       mark_q, nx_mark;
    logic [7:0]       sh, nx_sh;
    logic [7:0]       chk, nx_chk;
    logic [2:0]       bitn, nx_bitn;
    logic             half, nx_half;

    logic             tmr_load, expire;
    logic [CNT_W-1:0] tmr_dur;
    logic             feed_begin, take, has_byte, go_pay;
    logic [7:0]       feed_byte;

    tape_halfper_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .load   (tmr_load),
        .dur    (tmr_dur),
        .expire (expire)
    );

    tape_byte_feed #(.LEN_W(LEN_W)) u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .begin_i  (feed_begin),
        .len      (pay_len),
        .take     (take),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .has_byte (has_byte),
        .byte_o   (feed_byte)
    );

    assign tape_out = level;
    assign busy     = busy_q;
    assign done     = done_q;

    // Sequencer: next state, timer reloads and byte hand-off
    always_comb begin
        nx_phase    = phase;
        nx_kind     = kind;
        nx_level    = level;
        nx_busy     = busy_q;
        nx_done     = 1'b0;
        nx_pil_left = pil_left;
        nx_pay_left = pay_left;
        nx_mark     = mark_q;
        nx_sh       = sh;
        nx_chk      = chk;
        nx_bitn     = bitn;
        nx_half     = half;
        tmr_load    = 1'b0;
        tmr_dur     = '0;
        feed_begin  = 1'b0;
        go_pay      = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    nx_busy     = 1'b1;
                    feed_begin  = 1'b1;
                    nx_mark     = marker;
                    nx_pay_left = pay_len;
                    nx_pil_left = (pilot_halves != '0) ? pilot_halves :
                                  ((marker == 8'h00) ? N_HDR : N_DAT);
                    tmr_load    = 1'b1;
                    tmr_dur     = D_PILOT;
                    nx_phase    = PH_PILOT;
                end
            end
            PH_PILOT: begin
                if (expire) begin
                    nx_level = ~level;
                    tmr_load = 1'b1;
                    if (pil_left == PIL_W'(1)) begin
                        tmr_dur  = D_SYNC_A;
                        nx_phase = PH_SYNC_A;
                    end else begin
                        nx_pil_left = pil_left - PIL_W'(1);
                        tmr_dur     = D_PILOT;
                    end
                end
            end
            PH_SYNC_A: begin
                if (expire) begin
                    nx_level = ~level;
                    tmr_load = 1'b1;
                    tmr_dur  = D_SYNC_B;
                    nx_phase = PH_SYNC_B;
                end
            end
            PH_SYNC_B: begin
                if (expire) begin
                    nx_level = ~level;
                    nx_sh    = mark_q;
                    nx_chk   = mark_q;
                    nx_kind  = BK_MARK;
                    nx_bitn  = 3'd0;
                    nx_half  = 1'b0;
                    tmr_load = 1'b1;
                    tmr_dur  = dur_of(mark_q[7]);
                    nx_phase = PH_BYTE;
                end
            end
            PH_BYTE: begin
                if (expire) begin
                    nx_level = ~level;
                    if (!half) begin
                        nx_half  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_dur  = dur_of(sh[7]);
                    end else begin
                        nx_half = 1'b0;
                        if (bitn != 3'd7) begin
                            nx_bitn  = bitn + 3'd1;
                            nx_sh    = {sh[6:0], 1'b0};
                            tmr_load = 1'b1;
                            tmr_dur  = dur_of(sh[6]);
                        end else begin
                            nx_bitn = 3'd0;
                            if (kind != BK_SUM && pay_left != '0) begin
                                if (has_byte) go_pay = 1'b1;
                                else          nx_phase = PH_WAIT;
                            end else if (kind != BK_SUM) begin
                                nx_sh    = chk;
                                nx_kind  = BK_SUM;
                                tmr_load = 1'b1;
                                tmr_dur  = dur_of(chk[7]);
                            end else begin
                                nx_phase = PH_IDLE;
                                nx_busy  = 1'b0;
                                nx_done  = 1'b1;
                            end
                        end
                    end
                end
            end
            PH_WAIT: begin
                if (has_byte) go_pay = 1'b1;
            end
            default: nx_phase = PH_IDLE;
        endcase
        if (go_pay) begin
            nx_sh       = feed_byte;
            nx_chk      = chk ^ feed_byte;
            nx_kind     = BK_PAY;
            nx_pay_left = pay_left - LEN_W'(1);
            tmr_load    = 1'b1;
            tmr_dur     = dur_of(feed_byte[7]);
            nx_phase    = PH_BYTE;
        end
    end

    assign take = go_pay;

    // Sequencer state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            kind     <= BK_MARK;
            level    <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            pil_left <= '0;
            pay_left <= '0;
            mark_q   <= '0;
            sh       <= '0;
            chk      <= '0;
            bitn     <= '0;
            half     <= 1'b0;
        end else begin
            phase    <= nx_phase;
            kind     <= nx_kind;
            level    <= nx_level;
            busy_q   <= nx_busy;
            done_q   <= nx_done;
            pil_left <= nx_pil_left;
            pay_left <= nx_pay_left;
            mark_q   <= nx_mark;
            sh       <= nx_sh;
            chk      <= nx_chk;
            bitn     <= nx_bitn;
            half     <= nx_half;
        end
    end

endmodule

// File: rtl/tape_encoder_chk.sv
// Protocol checker for tape_encoder, attached by bind.
// Assumes rst_n is held low for at least one clock edge at power-up.
module tape_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic in_ready,
    input logic tape_out,
    input logic busy,
    input logic done
);

    // done lasts a single cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // busy is already low while done is shown
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // level is held between frames
    assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> $stable(tape_out));

    // no byte is requested outside a frame
    assert_ready_in_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    // a frame begins only on a start command
    assert_frame_from_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind tape_encoder tape_encoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_ready (in_ready),
    .tape_out (tape_out),
    .busy     (busy),
    .done     (done)
);

// File: tb/tape_encoder_test.sv
// Bench for tape_encoder with shortened timing constants.
module tape_encoder_test;

    localparam int PIL_W = 14;
    localparam int LEN_W = 16;
    localparam int P_PIL = 20;
    localparam int P_SA  = 7;
    localparam int P_SB  = 9;
    localparam int P_Z   = 5;
    localparam int P_O   = 11;
    localparam int N_HDR = 6;
    localparam int N_DAT = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             start = 1'b0;
    logic [7:0]       marker = 8'h00;
    logic [PIL_W-1:0] pilot_halves = '0;
    logic [LEN_W-1:0] pay_len = '0;
    logic [7:0]       in_data = 8'h00;
    logic             in_valid = 1'b0;
    logic             in_ready, tape_out, busy, done;

    tape_encoder #(
        .HP_PILOT(P_PIL), .HP_SYNC_A(P_SA), .HP_SYNC_B(P_SB),
        .HP_ZERO(P_Z), .HP_ONE(P_O), .PILOT_HDR(N_HDR), .PILOT_DAT(N_DAT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .marker(marker),
        .pilot_halves(pilot_halves), .pay_len(pay_len), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .tape_out(tape_out),
        .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int tick_mode = 0;
    logic tick_hold = 1'b1;
    logic [15:0] lfsr = 16'hACE1;
    int ticks_since = 0;
    int hl [0:1023];
    int nh = 0;
    int dcount = 0;
    logic prev_out = 1'b0;
    logic prev_busy = 1'b0;
    logic [7:0] pay [0:31];
    int acc = 0;
    logic acc_clr = 1'b1;
    logic feed_on = 1'b0;
    int offer = 0;
    int stall_at = -1;
    int stall_len = 0;
    int scnt = 0;
    int fN = 0;
    int flen = 0;
    logic [7:0] fmark = 8'h00;
    logic [7:0] fchk = 8'h00;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor half-periods, count done pulses, drive the tick pattern
    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            finish_run();
        end
        ticks_since += int'(tick);
        if (busy && !prev_busy) ticks_since = 0;
        if (tape_out != prev_out) begin
            if (nh < 1024) hl[nh] = ticks_since;
            nh++;
            ticks_since = 0;
        end
        if (done) dcount++;
        prev_out  = tape_out;
        prev_busy = busy;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (tick_hold)           tick = 1'b0;
        else if (tick_mode == 0) tick = 1'b1;
        else if (tick_mode == 1) tick = (cyc % 3 == 0);
        else                     tick = lfsr[0];
    end

    // Count accepted payload bytes
    always @(posedge clk) begin
        if (acc_clr)                acc <= 0;
        else if (in_valid && in_ready) acc <= acc + 1;
    end

    // Payload stream driver with optional stall window
    always @(negedge clk) begin
        if (acc_clr) scnt = 0;
        if (feed_on && acc < offer) begin
            if (acc == stall_at && scnt < stall_len) begin
                in_valid = 1'b0;
                scnt++;
            end else begin
                in_valid = 1'b1;
                in_data  = pay[acc];
            end
        end else begin
            in_valid = 1'b0;
        end
    end

    function automatic int exp_half(input int idx);
        int k, b, bi;
        logic [7:0] v;
        if (idx < fN) return P_PIL;
        if (idx == fN) return P_SA;
        if (idx == fN + 1) return P_SB;
        k  = idx - fN - 2;
        b  = k / 16;
        bi = 7 - (k % 16) / 2;
        if (b == 0)         v = fmark;
        else if (b <= flen) v = pay[b-1];
        else                v = fchk;
        return v[bi] ? P_O : P_Z;
    endfunction

    // Send one frame and check it; pat picks the payload pattern
    task automatic run_frame(input logic [7:0] mk, input int pil, input int len,
                             input int pat, input int tmode, input int st_at,
                             input bit poke);
        int total, bad_p, bad_s, bad_d, bad_pos, bit_err, byte_err;
        logic start_lvl, end_lvl;
        logic [7:0] dv;
        for (int i = 0; i < 32; i++) begin
            case (pat)
                0: pay[i] = 8'h00;
                1: pay[i] = 8'hFF;
                2: pay[i] = (i % 2 == 0) ? 8'hA5 : 8'h5A;
                default: pay[i] = 8'(i * 37 + 3);
            endcase
        end
        fmark = mk;
        flen  = len;
        fchk  = mk;
        for (int i = 0; i < len; i++) fchk = fchk ^ pay[i];
        fN = (pil != 0) ? pil : ((mk == 8'h00) ? N_HDR : N_DAT);
        total = fN + 2 + 16 * (len + 2);
        stall_at  = st_at;
        stall_len = (st_at >= 0) ? 600 : 0;
        offer = len + 3;
        tick_mode = tmode;
        tick_hold = 1'b1;
        acc_clr = 1'b1;
        feed_on = 1'b0;
        @(negedge clk);
        acc_clr = 1'b0;
        feed_on = 1'b1;
        start_lvl = tape_out;
        marker = mk;
        pilot_halves = PIL_W'(pil);
        pay_len = LEN_W'(len);
        start = 1'b1;
        @(negedge clk);
        nh = 0;
        dcount = 0;
        start = 1'b0;
        tick_hold = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            marker = ~mk;
            pilot_halves = PIL_W'(1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            marker = mk;
            repeat (300) @(negedge clk);
            marker = ~mk;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int w = 0; w < 40000 && dcount == 0; w++) @(negedge clk);
        end_lvl = tape_out;
        repeat (20) @(negedge clk);
        // R9: level held, single done pulse, idle afterwards
        check(tape_out == end_lvl, "R9 level hold after frame", int'(tape_out), int'(end_lvl));
        check(dcount == 1, "R9 done pulse count", dcount, 1);
        check(!busy, "R9 busy low after frame", int'(busy), 0);
        // R8: one inversion per half-period, starting from the prior level
        check(nh == total, "R8 half-period count", nh, total);
        check(end_lvl == (start_lvl ^ logic'(total % 2)), "R8 final level parity",
              int'(end_lvl), int'(start_lvl ^ logic'(total % 2)));
        // R12: exactly pay_len bytes accepted although more were offered
        check(acc == len, "R12 accepted byte count", acc, len);
        if (nh == total) begin
            bad_p = 0; bad_s = 0; bad_d = 0; bad_pos = -1;
            for (int i = 0; i < total; i++) begin
                if (hl[i] != exp_half(i)) begin
                    if (i < fN) bad_p++;
                    else if (i < fN + 2) bad_s++;
                    else begin bad_d++; bad_pos = i; end
                end
            end
            check(bad_p == 0, (pil != 0) ? "R2 pilot half lengths" : "R3 default pilot lengths", bad_p, 0);
            check(bad_s == 0, "R4 sync half lengths", bad_s, 0);
            if (st_at < 0) begin
                check(bad_d == 0, "R5 data half lengths", bad_d, 0);
            end else begin
                // R10: only the first half after the stall is lengthened
                check(bad_d == 1, "R10 stalled half count", bad_d, 1);
                check(bad_pos == fN + 2 + 16 * (st_at + 1), "R10 stall position",
                      bad_pos, fN + 2 + 16 * (st_at + 1));
                check(bad_pos >= 0 && hl[bad_pos] > 2 * P_O, "R10 level held during stall",
                      (bad_pos >= 0) ? hl[bad_pos] : -1, 2 * P_O + 1);
            end
            byte_err = 0;
            bit_err = 0;
            for (int b = 0; b < len + 2; b++) begin
                for (int bi = 0; bi < 8; bi++)
                    dv[7-bi] = hl[fN + 2 + 16 * b + 2 * bi + 1] > (P_Z + P_O) / 2;
                if (b <= len) begin
                    if (dv != ((b == 0) ? mk : pay[b-1])) byte_err++;
                end else begin
                    check(dv == fchk, "R7 checksum byte", int'(dv), int'(fchk));
                end
                for (int bi = 0; bi < 8; bi++)
                    if (hl[fN + 2 + 16 * b + 2 * bi] != hl[fN + 2 + 16 * b + 2 * bi + 1]
                        && fN + 2 + 16 * b + 2 * bi != bad_pos) bit_err++;
            end
            check(byte_err == 0, "R6 marker and payload order", byte_err, 0);
            check(bit_err == 0, "R5 equal halves per bit", bit_err, 0);
            if (poke) check(bad_p == 0 && bad_d == 0 && byte_err == 0,
                            "R11 mid-frame start ignored", bad_p + bad_d + byte_err, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!tape_out && !busy && !done && !in_ready, "R1 reset outputs",
              {tape_out, busy, done, in_ready}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!tape_out && !busy && !done && !in_ready, "R1 outputs after reset",
              {tape_out, busy, done, in_ready}, 0);
        for (int tm = 0; tm < 3; tm++) begin
            run_frame(8'hFF, 1, 5, 3, tm, -1, 0);
            run_frame(8'h00, 0, 17, 2, tm, -1, 0);
            run_frame(8'h3C, 3, 0, 0, tm, -1, 0);
            run_frame(8'hFF, 0, 1, 1, tm, -1, 0);
        end
        run_frame(8'h81, 2, 6, 3, 0, 2, 0);
        run_frame(8'h00, 0, 4, 2, 1, -1, 1);
        finish_run();
    end

endmodule